// File: doc/BRIEF.md
# Five-Port Speculative Virtual-Channel Router Core

This core moves wormhole packets between five ports of an on-chip network. A packet is a head flit followed by zero or more body flits and one tail flit. Only the head names a destination. Each input holds up to four flits in its own queue. When a head reaches the front of its queue, the core works out its output port by X-then-Y routing. In the same cycle it tries to claim an output virtual channel and a crossbar slot. If both succeed, the head leaves in that same cycle.

A head that claims a channel but loses the crossbar keeps the channel and competes only for the crossbar on later cycles. Body and tail flits reuse the route and channel of their head. The tail gives the channel back when it leaves. Crossbar conflicts go to the lowest-numbered input. Every output follows a valid/ready handshake, and a refused flit stays at the front of its queue.

Top module: `spec_vc_router`

## Requirements
- R1: After a synchronous active-low reset, every `in_ready` bit is 1 and every `out_valid` bit is 0.
- R2: Flit kinds are encoded in `*_type` as 2'b01 head, 2'b00 body and 2'b10 tail. The head's destination X is in data[7:4] and its destination Y is in data[3:0]. With the router at (2,2), the output is chosen as follows: X above 2 goes to port 1 (east); X below 2 goes to port 3 (west); otherwise Y above 2 goes to port 0 (north), Y below 2 goes to port 2 (south); when both match, the flit goes to port 4 (local).
- R3: A flit accepted at clock edge k into an otherwise idle path is transferred at edge k+1. This holds for a head too, because channel claim and crossbar grant happen in the same cycle.
- R4: A head claims the lowest-numbered free channel of its output. Every flit of that packet shows the same channel number on `out_vc`.
- R5: When several inputs request one output in a cycle, the lowest-numbered input wins.
- R6: Two heads that target the same output in the same cycle both claim distinct channels. The loser keeps its channel and is forwarded in the first cycle the output is free, still on that channel.
- R7: The flits of a packet leave in the order they entered, all through the head's output port.
- R8: While `out_ready` of an offered output is 0, no flit is removed, and that output keeps `out_valid` high on the next cycle.
- R9: An input holds at most four flits. Its `in_ready` is 0 while four flits are held.
- R10: A head whose output has no free channel is not forwarded until a channel of that output is released.
- R11: A tail leaving an output frees its channel, which a waiting head may claim from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Flit offered, one bit per input port |
| in_ready | output | 5 | Input queue can take a flit |
| in_data | input | 5 x 16 | Flit payload per input |
| in_type | input | 5 x 2 | Flit kind per input |
| out_valid | output | 5 | Flit offered, one bit per output port |
| out_ready | input | 5 | Downstream accepts the flit |
| out_data | output | 5 x 16 | Flit payload per output |
| out_type | output | 5 x 2 | Flit kind per output |
| out_vc | output | 5 x 1 | Output channel the flit travels on |

## Verification
A lone multi-flit packet on an idle path measures the single-cycle head latency and the ordering of body and tail flits. Two heads aimed at one output in the same cycle separate true speculative channel claiming from serial allocation: the loser must leave on channel 1 right after the winner's tail. A blocked output with a six-flit packet distinguishes correct stalling from lost or duplicated flits, and it exposes the full-queue ready. Three packets contending for a stalled output's two channels show that a third head waits and then reuses the channel the first tail freed. A burst to all five directions covers the routing decode.

// File: rtl/rtr_pkg.sv
// Shared constants for the router core: port numbering and flit kinds.
// Assumes five ports with index 0 highest in switch priority.
package rtr_pkg;
    localparam int NPORT   = 5;
    localparam int P_NORTH = 0;
    localparam int P_EAST  = 1;
    localparam int P_SOUTH = 2;
    localparam int P_WEST  = 3;
    localparam int P_LOCAL = 4;

    localparam logic [1:0] FT_BODY = 2'b00;
    localparam logic [1:0] FT_HEAD = 2'b01;
    localparam logic [1:0] FT_TAIL = 2'b10;
endpackage

// File: rtl/rtr_fifo.sv
// Input flit queue: DEPTH entries, show-ahead read port.
// Assumes DEPTH is a power of two; push is never asserted when full.
module rtr_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [AW:0]   count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // Front entry and status flags.
    always_comb begin
        rdata = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/rtr_route.sv
// Dimension-order route decode: X first, then Y, else local.
// Assumes coordinates are unsigned and the node sits at (MY_X, MY_Y).
module rtr_route #(
    parameter int CW   = 4,
    parameter int MY_X = 2,
    parameter int MY_Y = 2,
    parameter int PW   = 3
) (
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [PW-1:0] port
);
    import rtr_pkg::*;

    // Compare destination with own position, X dimension first.
    always_comb begin
        if (dst_x > CW'(MY_X))      port = PW'(P_EAST);
        else if (dst_x < CW'(MY_X)) port = PW'(P_WEST);
        else if (dst_y > CW'(MY_Y)) port = PW'(P_NORTH);
        else if (dst_y < CW'(MY_Y)) port = PW'(P_SOUTH);
        else                        port = PW'(P_LOCAL);
    end
endmodule

// File: rtl/rtr_vc_alloc.sv
// Output channel allocator: keeps a busy bit per output channel and hands
// free channels to waiting heads, lowest input first, lowest channel first.
// Several heads may win channels of one output in the same cycle.
module rtr_vc_alloc #(
    parameter int NP   = 5,
    parameter int NVC  = 2,
    parameter int PW   = 3,
    parameter int VCW  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NP-1:0]            need,
    input  logic [NP-1:0][PW-1:0]    want,
    input  logic [NP-1:0]            rel,
    input  logic [NP-1:0][VCW-1:0]   rel_vc,
    output logic [NP-1:0]            win,
    output logic [NP-1:0][VCW-1:0]   win_vc,
    output logic [NP-1:0][NVC-1:0]   vc_busy
);
    logic [NP-1:0][NVC-1:0] taken;

    // Walk requesters in priority order, each taking the lowest free channel.
    always_comb begin
        taken  = vc_busy;
        win    = '0;
        win_vc = '0;
        for (int i = 0; i < NP; i++) begin
            for (int v = 0; v < NVC; v++) begin
                if (need[i] && !win[i] && !taken[want[i]][v]) begin
                    win[i]             = 1'b1;
                    win_vc[i]          = VCW'(v);
                    taken[want[i]][v]  = 1'b1;
                end
            end
        end
    end

    // Free channels on tail departure, mark new claims busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_busy <= '0;
        end else begin
            for (int o = 0; o < NP; o++)
                if (rel[o]) vc_busy[o][rel_vc[o]] <= 1'b0;
            for (int i = 0; i < NP; i++)
                if (win[i]) vc_busy[want[i]][win_vc[i]] <= 1'b1;
        end
    end
endmodule

// File: rtl/rtr_sw_arb.sv
// Crossbar arbiter: per output, the lowest-numbered requesting input wins.
// Purely combinational; grants do not depend on downstream ready.
module rtr_sw_arb #(
    parameter int NP = 5,
    parameter int PW = 3
) (
    input  logic [NP-1:0]          req,
    input  logic [NP-1:0][PW-1:0]  req_port,
    output logic [NP-1:0]          gnt,
    output logic [NP-1:0]          osel_v,
    output logic [NP-1:0][PW-1:0]  osel
);
    // Fixed-priority pick per output, scanning from lowest priority up.
    always_comb begin
        osel_v = '0;
        osel   = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = NP-1; i >= 0; i--) begin
                if (req[i] && req_port[i] == PW'(o)) begin
                    osel_v[o] = 1'b1;
                    osel[o]   = PW'(i);
                end
            end
        end
    end

    // Tell each input whether it won its output.
    always_comb begin
        for (int i = 0; i < NP; i++)
            gnt[i] = req[i] && osel_v[req_port[i]] && osel[req_port[i]] == PW'(i);
    end
endmodule

// File: rtl/spec_vc_router.sv
// Five-port wormhole router core with speculative allocation: channel claim
// and crossbar grant are resolved in one cycle, and a winner of both crosses
// at once. Assumes well-formed packets (head, bodies, tail; at least 2 flits).
module spec_vc_router #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int NVC   = 2,
    parameter int CW    = 4,
    parameter int MY_X  = 2,
    parameter int MY_Y  = 2,
    localparam int NP   = rtr_pkg::NPORT,
    localparam int PW   = $clog2(NP),
    localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NP-1:0]           in_valid,
    output logic [NP-1:0]           in_ready,
    input  logic [NP-1:0][DW-1:0]   in_data,
    input  logic [NP-1:0][1:0]      in_type,
    output logic [NP-1:0]           out_valid,
    input  logic [NP-1:0]           out_ready,
    output logic [NP-1:0][DW-1:0]   out_data,
    output logic [NP-1:0][1:0]      out_type,
    output logic [NP-1:0][VCW-1:0]  out_vc
);
    import rtr_pkg::*;

    logic [NP-1:0][DW-1:0]  f_data;
    logic [NP-1:0][1:0]     f_type;
    logic [NP-1:0]          f_empty;
    logic [NP-1:0]          f_full;
    logic [NP-1:0][AW:0]    fill;
    logic [NP-1:0][PW-1:0]  rt_c;
    logic [NP-1:0][PW-1:0]  cur_port;
    logic [NP-1:0][VCW-1:0] cur_vc;
    logic [NP-1:0]          need, sw_req, move;
    logic [NP-1:0]          vc_win, gnt, osel_v, rel;
    logic [NP-1:0][VCW-1:0] win_vc, rel_vc;
    logic [NP-1:0][PW-1:0]  osel;
    logic [NP-1:0][NVC-1:0] vc_busy;
    logic [NP-1:0]          hold_q;
    logic [NP-1:0][PW-1:0]  route_q;
    logic [NP-1:0][VCW-1:0] vc_q;

    assign in_ready = ~f_full;

    // One queue and one route decoder per input port.
    for (genvar i = 0; i < NP; i++) begin : g_in
        rtr_fifo #(.W(DW+2), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i] && in_ready[i]),
            .wdata ({in_type[i], in_data[i]}),
            .pop   (move[i]),
            .rdata ({f_type[i], f_data[i]}),
            .empty (f_empty[i]),
            .full  (f_full[i]),
            .count (fill[i])
        );
        rtr_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y), .PW(PW)) u_route (
            .dst_x (f_data[i][2*CW-1:CW]),
            .dst_y (f_data[i][CW-1:0]),
            .port  (rt_c[i])
        );
    end

    rtr_vc_alloc #(.NP(NP), .NVC(NVC), .PW(PW), .VCW(VCW)) u_vca (
        .clk     (clk),
        .rst_n   (rst_n),
        .need    (need),
        .want    (rt_c),
        .rel     (rel),
        .rel_vc  (rel_vc),
        .win     (vc_win),
        .win_vc  (win_vc),
        .vc_busy (vc_busy)
    );

    rtr_sw_arb #(.NP(NP), .PW(PW)) u_swa (
        .req      (sw_req),
        .req_port (cur_port),
        .gnt      (gnt),
        .osel_v   (osel_v),
        .osel     (osel)
    );

    // Per-input request formation: held packets ask only for the switch,
    // new heads ask for a channel and, speculatively, the switch.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            cur_port[i] = hold_q[i] ? route_q[i] : rt_c[i];
            cur_vc[i]   = hold_q[i] ? vc_q[i]    : win_vc[i];
            need[i]     = !f_empty[i] && !hold_q[i] && f_type[i] == FT_HEAD;
            sw_req[i]   = !f_empty[i] && (hold_q[i] || vc_win[i]);
            move[i]     = gnt[i] && out_ready[cur_port[i]];
        end
    end

    // Crossbar: steer the selected input to each output; flag tail releases.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            out_valid[o] = osel_v[o];
            out_data[o]  = f_data[osel[o]];
            out_type[o]  = f_type[osel[o]];
            out_vc[o]    = cur_vc[osel[o]];
            rel[o]       = osel_v[o] && out_ready[o] && f_type[osel[o]] == FT_TAIL;
            rel_vc[o]    = cur_vc[osel[o]];
        end
    end

    // Per-input packet state: route and channel kept from head to tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            route_q <= '0;
            vc_q    <= '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (move[i] && f_type[i] == FT_TAIL) begin
                    hold_q[i] <= 1'b0;
                end else if (vc_win[i]) begin
                    hold_q[i]  <= 1'b1;
                    route_q[i] <= rt_c[i];
                    vc_q[i]    <= win_vc[i];
                end
            end
        end
    end
endmodule

// File: rtl/rtr_checker.sv
// Property checker for the router core, attached by bind.
// Assumes the port numbering and flit kinds of rtr_pkg.
module rtr_checker #(
    parameter int NP    = 5,
    parameter int NVC   = 2,
    parameter int VCW   = 1,
    parameter int AW    = 2,
    parameter int DEPTH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NP-1:0]           out_valid,
    input logic [NP-1:0]           out_ready,
    input logic [NP-1:0][1:0]      out_type,
    input logic [NP-1:0][VCW-1:0]  out_vc,
    input logic [NP-1:0][NVC-1:0]  vc_busy,
    input logic [NP-1:0][AW:0]     fill
);
    import rtr_pkg::*;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> out_valid == '0); // R1

    for (genvar p = 0; p < NP; p++) begin : g_p
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            fill[p] <= (AW+1)'(DEPTH)); // R9

        AST_HEAD_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && out_ready[p] && out_type[p] == FT_HEAD)
            |=> vc_busy[p][$past(out_vc[p])]); // R4

        AST_TAIL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && out_ready[p] && out_type[p] == FT_TAIL)
            |=> !vc_busy[p][$past(out_vc[p])]); // R11

        AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=> out_valid[p]); // R8
    end
endmodule

bind spec_vc_router rtr_checker #(
    .NP(NP), .NVC(NVC), .VCW(VCW), .AW(AW), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_type  (out_type),
    .out_vc    (out_vc),
    .vc_busy   (vc_busy),
    .fill      (fill)
);

// File: tb/spec_vc_router_tb.sv
`timescale 1ns/1ps
module spec_vc_router_tb;
    typedef logic [17:0] fl_t;
    typedef struct packed {logic [31:0] cyc; logic [15:0] d; logic [1:0] t; logic [31:0] vc;} rec_t;
    typedef struct packed {logic [31:0] cyc; logic [15:0] d;} acc_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       in_valid = '0;
    logic [4:0]       in_ready;
    logic [4:0][15:0] in_data = '0;
    logic [4:0][1:0]  in_type = '0;
    logic [4:0]       out_valid;
    logic [4:0]       out_ready = '1;
    logic [4:0][15:0] out_data;
    logic [4:0][1:0]  out_type;
    logic [4:0][0:0]  out_vc;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    fl_t  src [5][$];
    fl_t  fq  [5][$];
    rec_t olog[5][$];
    acc_t alog[5][$];
    bit   m_hold [5];
    int   m_route[5];
    int   m_vc   [5];
    bit   m_busy [5][2];

    always #4 clk = ~clk;

    spec_vc_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_type(in_type),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_type(out_type), .out_vc(out_vc)
    );

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int xy(int x, int y);
        if (x > 2) return 1;
        if (x < 2) return 3;
        if (y > 2) return 0;
        if (y < 2) return 2;
        return 4;
    endfunction

    task automatic send(int i, int tag, int x, int y, int n);
        src[i].push_back({2'b01, tag[7:0], x[3:0], y[3:0]});
        for (int k = 1; k < n - 1; k++) src[i].push_back({2'b00, tag[7:0], k[7:0]});
        src[i].push_back({2'b10, tag[7:0], 8'(n - 1)});
    endtask

    task automatic clear_logs();
        for (int i = 0; i < 5; i++) begin
            olog[i].delete();
            alog[i].delete();
        end
    endtask

    // One clock of stimulus, model comparison and model advance.
    task automatic step();
        bit  wvc[5];
        int  wv[5];
        bit  sreq[5];
        int  sport[5];
        int  svc[5];
        int  gsel[5];
        bit  erdy[5];
        bit  tk[5][2];
        fl_t f;
        for (int i = 0; i < 5; i++) begin
            in_valid[i] = src[i].size() != 0;
            in_data[i]  = in_valid[i] ? src[i][0][15:0] : 16'h0;
            in_type[i]  = in_valid[i] ? src[i][0][17:16] : 2'b00;
        end
        #1;
        tk = m_busy;
        for (int i = 0; i < 5; i++) begin
            wvc[i] = 0; sreq[i] = 0; sport[i] = 0; svc[i] = 0; wv[i] = 0;
            erdy[i] = fq[i].size() < 4;
            if (fq[i].size() > 0) begin
                f = fq[i][0];
                if (m_hold[i]) begin
                    sreq[i] = 1; sport[i] = m_route[i]; svc[i] = m_vc[i];
                end else if (f[17:16] == 2'b01) begin
                    int p;
                    p = xy(int'(f[7:4]), int'(f[3:0]));
                    for (int v = 0; v < 2; v++)
                        if (!wvc[i] && !tk[p][v]) begin
                            wvc[i] = 1; wv[i] = v; tk[p][v] = 1;
                        end
                    if (wvc[i]) begin
                        sreq[i] = 1; sport[i] = p; svc[i] = wv[i];
                    end
                end
            end
            chk("R9", $sformatf("in_ready[%0d]", i), int'(in_ready[i]), int'(erdy[i]));
        end
        for (int o = 0; o < 5; o++) begin
            gsel[o] = -1;
            for (int i = 0; i < 5; i++)
                if (gsel[o] < 0 && sreq[i] && sport[i] == o) gsel[o] = i;
            chk("R5", $sformatf("out_valid[%0d]", o), int'(out_valid[o]), int'(gsel[o] >= 0));
            if (gsel[o] >= 0 && out_valid[o]) begin
                f = fq[gsel[o]][0];
                chk("R2", $sformatf("out_data[%0d]", o), int'(out_data[o]), int'(f[15:0]));
                chk("R7", $sformatf("out_type[%0d]", o), int'(out_type[o]), int'(f[17:16]));
                chk("R4", $sformatf("out_vc[%0d]", o), int'(out_vc[o]), svc[gsel[o]]);
            end
        end
        // Model advance: claims, then departures, then arrivals.
        for (int i = 0; i < 5; i++)
            if (wvc[i]) begin
                m_hold[i] = 1; m_route[i] = sport[i]; m_vc[i] = wv[i];
                m_busy[sport[i]][wv[i]] = 1;
            end
        for (int o = 0; o < 5; o++)
            if (gsel[o] >= 0 && out_ready[o]) begin
                f = fq[gsel[o]].pop_front();
                olog[o].push_back({32'(cyc), f[15:0], f[17:16], 32'(svc[gsel[o]])});
                if (f[17:16] == 2'b10) begin
                    m_busy[o][svc[gsel[o]]] = 0;
                    m_hold[gsel[o]] = 0;
                end
            end
        for (int i = 0; i < 5; i++)
            if (src[i].size() != 0 && erdy[i]) begin
                f = src[i].pop_front();
                fq[i].push_back(f);
                alog[i].push_back({32'(cyc), f[15:0]});
            end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            m_hold[i] = 0; m_route[i] = 0; m_vc[i] = 0;
            m_busy[i][0] = 0; m_busy[i][1] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk("R1", "in_ready after reset", int'(in_ready), 31);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        @(negedge clk);

        // Lone three-flit packet local -> east: latency, route, order.
        clear_logs();
        send(4, 8'hA1, 3, 2, 3);
        run(8);
        chk("R7", "east flit count", olog[1].size(), 3);
        if (olog[1].size() == 3 && alog[4].size() == 3) begin
            chk("R3", "head one-cycle forwarding", int'(olog[1][0].cyc), int'(alog[4][0].cyc) + 1);
            chk("R2", "head data at east", int'(olog[1][0].d), 16'hA132);
            chk("R4", "head takes channel 0", int'(olog[1][0].vc), 0);
            for (int k = 0; k < 3; k++) begin
                chk("R7", "flit order", int'(olog[1][k].d), int'(alog[4][k].d));
                chk("R4", "packet stays on channel", int'(olog[1][k].vc), 0);
            end
            chk("R7", "kinds head/body/tail", {olog[1][0].t, olog[1][1].t, olog[1][2].t}, 6'b01_00_10);
        end

        // Two heads to local output in the same cycle.
        clear_logs();
        send(0, 8'hB0, 2, 2, 2);
        send(3, 8'hB3, 2, 2, 2);
        run(10);
        chk("R6", "local flit count", olog[4].size(), 4);
        if (olog[4].size() == 4) begin
            chk("R5", "input 0 wins first", int'(olog[4][0].d[15:8]), 8'hB0);
            chk("R3", "winner head latency", int'(olog[4][0].cyc), int'(alog[0][0].cyc) + 1);
            chk("R7", "winner tail next", int'(olog[4][1].d[15:8]), 8'hB0);
            chk("R6", "loser follows", int'(olog[4][2].d[15:8]), 8'hB3);
            chk("R6", "loser kept channel 1", int'(olog[4][2].vc), 1);
            chk("R6", "loser retries at once", int'(olog[4][2].cyc), int'(olog[4][0].cyc) + 2);
            chk("R4", "loser tail on channel 1", int'(olog[4][3].vc), 1);
        end

        // Back-pressure on east with a six-flit packet.
        clear_logs();
        out_ready[1] = 1'b0;
        send(4, 8'hC4, 3, 2, 6);
        run(7);
        chk("R8", "nothing leaves while stalled", olog[1].size(), 0);
        chk("R8", "east still offered", int'(out_valid[1]), 1);
        chk("R9", "in_ready low with four held", int'(in_ready[4]), 0);
        chk("R9", "four flits taken", alog[4].size(), 4);
        out_ready[1] = 1'b1;
        run(12);
        chk("R8", "all flits delivered", olog[1].size(), 6);
        if (olog[1].size() == 6 && alog[4].size() == 6)
            for (int k = 0; k < 6; k++)
                chk("R7", "order after stall", int'(olog[1][k].d), int'(alog[4][k].d));

        // Channel exhaustion on a stalled south output.
        clear_logs();
        out_ready[2] = 1'b0;
        send(0, 8'hD0, 2, 0, 2);
        send(1, 8'hD1, 2, 1, 2);
        send(3, 8'hD3, 2, 0, 2);
        run(6);
        chk("R8", "south blocked", olog[2].size(), 0);
        out_ready[2] = 1'b1;
        run(12);
        chk("R10", "south flit count", olog[2].size(), 6);
        if (olog[2].size() == 6) begin
            chk("R5", "D0 first", int'(olog[2][0].d[15:8]), 8'hD0);
            chk("R4", "D1 on channel 1", int'(olog[2][2].vc), 1);
            chk("R10", "third head after a tail", int'(olog[2][4].d[15:8]), 8'hD3);
            chk("R10", "third head waited", int'(olog[2][4].cyc > olog[2][1].cyc), 1);
            chk("R11", "freed channel 0 reused", int'(olog[2][4].vc), 0);
        end

        // One packet to every direction at once.
        clear_logs();
        send(4, 8'hE0, 2, 3, 2);
        send(3, 8'hE1, 3, 2, 2);
        send(1, 8'hE2, 2, 0, 2);
        send(2, 8'hE3, 0, 2, 2);
        send(0, 8'hE4, 2, 2, 2);
        run(8);
        for (int p = 0; p < 5; p++) begin
            chk("R2", $sformatf("port %0d count", p), olog[p].size(), 2);
            if (olog[p].size() == 2)
                chk("R2", $sformatf("port %0d tag", p), int'(olog[p][0].d[15:8]), 8'hE0 + p);
        end
        if (olog[1].size() == 2 && alog[3].size() == 2)
            chk("R3", "uncontended east latency", int'(olog[1][0].cyc), int'(alog[3][0].cyc) + 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule